// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Doubling

This block performs 32-bit signed arithmetic that clamps instead of wrapping, as used in fixed-point DSP kernels. Each accepted operation takes two signed operands and a 2-bit operation code. It produces a registered result one clock later, together with a one-cycle indication that some saturation happened. The surrounding pipeline uses that indication to set its own sticky overflow bit.

There are four operations: plain add, plain subtract, and two doubling variants. In a doubling variant the second operand is first added to itself. That doubled value is clamped to the signed range if it overflows, and only then added to or subtracted from the first operand, with a second clamp. Either clamp raises the indication. When both clamp, the indication is still a single bit for that one result.

Top module: `sat_dsp_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears `out_valid`, `sat_flag` and `result` to zero, whatever the other inputs are.
- R2: `out_valid` is high in the cycle after each edge at which `in_valid` was high, and low after each edge at which it was low, so back-to-back operations each produce one result.
- R3: Operation code 2'b00 returns `opa + opb` when the true sum fits in 32 signed bits, with `sat_flag` low.
- R4: Operation code 2'b01 returns `opa - opb` when the true difference fits, with `sat_flag` low.
- R5: For code 2'b00, a sum above 0x7FFFFFFF returns 0x7FFFFFFF and a sum below -2^31 returns 0x80000000, and `sat_flag` is high in both cases.
- R6: For code 2'b01, a difference out of range clamps to 0x7FFFFFFF (too large) or 0x80000000 (too small), with `sat_flag` high.
- R7: Code 2'b10 returns the clamped value of `opa` plus the clamped value of 2*`opb`. Code 2'b11 returns the clamped value of `opa` minus the clamped value of 2*`opb`.
- R8: In the doubling codes, 2*`opb` is clamped to the signed range before the second step. If it overflows, `sat_flag` is high even when the second step does not overflow; for example, `opa`=-1 and `opb`=0x40000000 under 2'b10 gives 0x7FFFFFFE.
- R9: `sat_flag` is a single bit that is high only together with `out_valid`, including when both doubling stages clamp.
- R10: A result that lands exactly on 0x7FFFFFFF or 0x80000000 without exceeding the range leaves `sat_flag` low.
- R11: After an edge with `in_valid` low, `result` keeps its previous value and `sat_flag` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and operation code are presented this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 add doubled, 11 subtract doubled |
| opa | input | 32 | First signed operand |
| opb | input | 32 | Second signed operand (the one doubled) |
| out_valid | output | 1 | A result is presented |
| result | output | 32 | Saturated signed result |
| sat_flag | output | 1 | Some saturation occurred for this result |

## Verification
The hardest case to reach is the one where the doubling clamp changes the final answer. Here the first stage saturates but the second does not, so a design that skips the first clamp and lets the wrapped value flow on gives a different number. The stimulus targets this with operands just past the doubling limit (0x40000000 and 0x80000000) paired with a first operand of the opposite sign. It also covers the case where both stages clamp, to confirm the flag stays a single bit. Results that land exactly on each limit are applied next to cases one step past the limit, so the flag's threshold is tested from both sides.

// File: rtl/sat_dsp_pkg.sv
package sat_dsp_pkg;

    parameter int DATA_W = 32;

    localparam logic [DATA_W-1:0] POS_LIMIT = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIMIT = {1'b1, {(DATA_W-1){1'b0}}};

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_DADD = 2'b10,
        OP_DSUB = 2'b11
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              sat;
    } sat_res_t;

    // Overflow of a + b = s: operands agree in sign, sum disagrees.
    function automatic logic add_ovf(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b,
                                     input logic [DATA_W-1:0] s);
        return (a[DATA_W-1] == b[DATA_W-1]) && (s[DATA_W-1] != a[DATA_W-1]);
    endfunction

    // Overflow of a - b = d: operands differ in sign, difference leaves a's sign.
    function automatic logic sub_ovf(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b,
                                     input logic [DATA_W-1:0] d);
        return (a[DATA_W-1] != b[DATA_W-1]) && (d[DATA_W-1] != a[DATA_W-1]);
    endfunction

    // A wrapped result that reads negative came from a positive overflow.
    function automatic logic [DATA_W-1:0] clamp_of(input logic [DATA_W-1:0] wrapped);
        return wrapped[DATA_W-1] ? POS_LIMIT : NEG_LIMIT;
    endfunction

    function automatic sat_res_t sat_sum(input logic [DATA_W-1:0] a,
                                         input logic [DATA_W-1:0] b,
                                         input logic              do_sub);
        sat_res_t          r;
        logic [DATA_W-1:0] raw;
        logic              ovf;
        raw = do_sub ? (a - b) : (a + b);
        ovf = do_sub ? sub_ovf(a, b, raw) : add_ovf(a, b, raw);
        r.value = ovf ? clamp_of(raw) : raw;
        r.sat   = ovf;
        return r;
    endfunction

endpackage

// File: rtl/sat_dsp_doubler.sv
module sat_dsp_doubler
    import sat_dsp_pkg::*;
(
    input  logic [DATA_W-1:0] operand,
    output sat_res_t          doubled
);
    always_comb begin
        doubled = sat_sum(operand, operand, 1'b0);
    end
endmodule

// File: rtl/sat_dsp_addsub.sv
module sat_dsp_addsub
    import sat_dsp_pkg::*;
(
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              subtract,
    output sat_res_t          outcome
);
    always_comb begin
        outcome = sat_sum(lhs, rhs, subtract);
    end
endmodule

// File: rtl/sat_dsp_alu.sv
module sat_dsp_alu
    import sat_dsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    op_e               op_sel;
    logic              dbl_mode;
    logic              sub_mode;
    sat_res_t          dbl_r;
    sat_res_t          fin_r;
    logic [DATA_W-1:0] rhs_sel;
    logic              any_sat;

    assign op_sel   = op_e'(op);
    assign dbl_mode = (op_sel == OP_DADD) || (op_sel == OP_DSUB);
    assign sub_mode = (op_sel == OP_SUB)  || (op_sel == OP_DSUB);

    sat_dsp_doubler u_dbl (
        .operand (opb),
        .doubled (dbl_r)
    );

    assign rhs_sel = dbl_mode ? dbl_r.value : opb;

    sat_dsp_addsub u_fin (
        .lhs      (opa),
        .rhs      (rhs_sel),
        .subtract (sub_mode),
        .outcome  (fin_r)
    );

    assign any_sat = fin_r.sat | (dbl_mode & dbl_r.sat);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            sat_flag  <= in_valid & any_sat;
            if (in_valid) begin
                result <= fin_r.value;
            end
        end
    end
endmodule

// File: rtl/sat_dsp_alu_chk.sv
module sat_dsp_alu_chk
    import sat_dsp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        op,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              sat_flag
);
    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && out_valid) |=> ($stable(result) && !sat_flag));

    assert_add_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b00 && !opa[DATA_W-1] && !opb[DATA_W-1]) |=> !result[DATA_W-1]);

    assert_sub_sign_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b01 && !opa[DATA_W-1] && opb[DATA_W-1]) |=> !result[DATA_W-1]);

    assert_dbl_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[1] && (opb[DATA_W-1] != opb[DATA_W-2])) |=> sat_flag);

    assert_flag_qual_R9: assert property (@(posedge clk) disable iff (rst)
        sat_flag |-> out_valid);
endmodule

bind sat_dsp_alu sat_dsp_alu_chk chk_i (.*);

// File: tb/sat_dsp_alu_tb_top.sv
module sat_dsp_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        sat_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] last_result = '0;

    localparam longint MAXV = 64'sd2147483647;
    localparam longint MINV = -64'sd2147483648;

    always #4 clk = ~clk;

    sat_dsp_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .out_valid(out_valid),
        .result(result), .sat_flag(sat_flag)
    );

    function automatic void model(input logic [1:0] o, input logic [31:0] a,
                                  input logic [31:0] b, output logic [31:0] r,
                                  output logic f);
        longint sa;
        longint sb;
        longint x;
        longint t;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        f  = 1'b0;
        if (o[1]) begin
            x = sb * 2;
            if (x > MAXV) begin x = MAXV; f = 1'b1; end
            else if (x < MINV) begin x = MINV; f = 1'b1; end
        end else begin
            x = sb;
        end
        t = o[0] ? (sa - x) : (sa + x);
        if (t > MAXV) begin t = MAXV; f = 1'b1; end
        else if (t < MINV) begin t = MINV; f = 1'b1; end
        r = t[31:0];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one operation with in_valid high; check at the following negedge.
    task automatic run_op(input string req, input logic [1:0] o,
                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic        ef;
        model(o, a, b, er, ef);
        in_valid = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        check(req, "out_valid", {31'd0, out_valid}, 32'd1);
        check(req, "result", result, er);
        check(req, "sat_flag", {31'd0, sat_flag}, {31'd0, ef});
        last_result = er;
    endtask

    task automatic idle_cycle(input string req);
        in_valid = 1'b0; op = 2'b11; opa = 32'h7FFFFFFF; opb = 32'h80000000;
        @(negedge clk);
        check(req, "idle out_valid", {31'd0, out_valid}, 32'd0);
        check(req, "idle sat_flag", {31'd0, sat_flag}, 32'd0);
        check(req, "idle result", result, last_result);
    endtask

    task automatic test_reset();
        in_valid = 1'b1; op = 2'b00; opa = 32'h7FFFFFFF; opb = 32'h1;
        repeat (3) @(negedge clk);
        check("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R1", "reset result", result, 32'd0);
        check("R1", "reset sat_flag", {31'd0, sat_flag}, 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R2", "no valid after reset", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic test_plain();
        run_op("R3", 2'b00, 32'd100, 32'hFFFFFFF6);
        run_op("R3", 2'b00, 32'h12345678, 32'h01010101);
        run_op("R4", 2'b01, 32'd5, 32'd9);
        run_op("R4", 2'b01, 32'h80000005, 32'h00000004);
        idle_cycle("R11");
    endtask

    task automatic test_limits();
        run_op("R5", 2'b00, 32'h7FFFFFFF, 32'h00000001);
        run_op("R5", 2'b00, 32'h80000000, 32'hFFFFFFFF);
        run_op("R6", 2'b01, 32'h7FFFFFF0, 32'hFFFFFF00);
        run_op("R6", 2'b01, 32'h80000010, 32'h00000100);
        idle_cycle("R11");
    endtask

    task automatic test_exact();
        run_op("R10", 2'b00, 32'h7FFFFFFE, 32'h00000001);
        run_op("R10", 2'b01, 32'h80000001, 32'h00000001);
        run_op("R10", 2'b10, 32'h00000001, 32'h3FFFFFFF);
        run_op("R10", 2'b11, 32'h00000000, 32'h40000000);
        idle_cycle("R11");
    endtask

    task automatic test_doubling();
        run_op("R7", 2'b10, 32'd10, 32'd7);
        run_op("R7", 2'b11, 32'd10, 32'd7);
        run_op("R8", 2'b10, 32'hFFFFFFFF, 32'h40000000);
        run_op("R8", 2'b10, 32'h00000000, 32'h80000000);
        run_op("R8", 2'b11, 32'hFFFFFFFF, 32'hBFFFFFFF);
        run_op("R9", 2'b11, 32'h00000000, 32'h80000000);
        idle_cycle("R9");
        run_op("R9", 2'b10, 32'h7FFFFFFF, 32'h7FFFFFFF);
        idle_cycle("R11");
    endtask

    task automatic test_stream();
        for (int i = 0; i < 8; i++) begin
            run_op("R2", 2'(i), 32'h30000000 + 32'(i) * 32'h11111111,
                   32'h50000000 - 32'(i) * 32'h0F0F0F0F);
        end
        idle_cycle("R2");
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_plain();
        test_limits();
        test_exact();
        test_doubling();
        test_stream();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule